// File: doc/BRIEF.md
# Early transmit underrun guard

This block lets a packet start going out on the wire while the host is still copying it into buffer memory. Every cycle it compares the position the transmit DMA wants to read against the position the host has loaded up to. If the reader has overtaken the writer, the block withholds data from the transmit DMA. This starves the DMA into an underrun, so no byte that was never written is ever sent.

Two compare modes exist. The plain mode compares addresses only. The packet-qualified mode also requires the packet number being loaded to equal the packet number being sent. A build-time parameter says whether the mode bit exists at all; without it, the plain mode is always used.

The block can also start a transmit by itself. It counts the bytes the host writes into the current packet, and once a programmable threshold is reached it issues a single start pulse. No host command is needed.

Top module: `etx_underrun_guard`

## Requirements
- R1: While `early_en` is 0, `dma_stall` stays 0 and `underrun` is never newly set, whatever the addresses are.
- R2: In plain mode (`mode_pkt`=0) with `early_en`=1 and `dma_rd`=1, `dma_stall` is 1 in the same cycle when `dma_addr` is strictly greater than `host_addr`. Equal addresses do not stall.
- R3: In packet-qualified mode (`mode_pkt`=1), the stall condition of R2 also requires `dma_pkt` to equal `host_pkt`. With different packet numbers there is no stall.
- R4: When the parameter `HAS_MODE_SEL` is 0, `mode_pkt` has no effect and the plain compare of R2 applies.
- R5: After a stall condition, `dma_stall` stays 1 on every following cycle until a cycle with `pkt_end`=1. It is 0 from the cycle after that one, unless a new stall condition occurs.
- R6: `underrun` goes to 1 on the cycle after a stall condition. It holds until a cycle with `urun_clr`=1 and no new stall condition. A stall condition in the same cycle as `urun_clr` keeps the flag set.
- R7: With `early_en`=1, `auto_en`=1 and `rcv_sel`=0, `auto_start` pulses high for exactly one cycle. The pulse comes on the cycle after the one in which the count of `load_wr` cycles since the last `load_new` is at least `auto_thresh`.
- R8: At most one `auto_start` pulse is issued per packet. `load_new` clears the byte count and re-arms the pulse.
- R9: No `auto_start` pulse is issued while `rcv_sel`=1, `auto_en`=0 or `early_en`=0.
- R10: During and right after reset, `dma_stall`, `underrun` and `auto_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| early_en | input | 1 | Enables underrun detection and auto start |
| mode_pkt | input | 1 | 1 selects the packet-qualified compare |
| auto_en | input | 1 | Enables automatic transmit start |
| rcv_sel | input | 1 | Receive selected; blocks auto start |
| auto_thresh | input | CNT_W | Loaded byte count that triggers auto start |
| host_addr | input | ADDR_W | Host load position |
| host_pkt | input | PKT_W | Packet number being loaded |
| load_wr | input | 1 | Host wrote one byte this cycle |
| load_new | input | 1 | Host begins a new packet |
| dma_rd | input | 1 | Transmit DMA requests a read this cycle |
| dma_addr | input | ADDR_W | Transmit DMA read position |
| dma_pkt | input | PKT_W | Packet number being transmitted |
| pkt_end | input | 1 | Transmitted packet finished |
| urun_clr | input | 1 | Host clears the underrun flag |
| dma_stall | output | 1 | Withhold data from the transmit DMA |
| underrun | output | 1 | Latched underrun flag |
| auto_start | output | 1 | One-cycle automatic transmit start |

## Verification
A wrong compare appears on `dma_stall` in the same cycle as the offending read. A lost or stuck latch appears one cycle later on `underrun`, or on the next stall cycle after the read position falls back. A broken byte counter or arm flag shows up as a missing, early, late or repeated `auto_start` pulse. This is visible within one cycle of the threshold being met, or on the idle cycles after it. A second instance built without the mode bit shows whether that bit is ignored.

// File: rtl/etx_underrun_guard.sv
module etx_underrun_guard #(
  parameter int ADDR_W = 11,
  parameter int PKT_W = 6,
  parameter int CNT_W = 11,
  parameter bit HAS_MODE_SEL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              early_en,
  input  logic              mode_pkt,
  input  logic              auto_en,
  input  logic              rcv_sel,
  input  logic [CNT_W-1:0]  auto_thresh,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [PKT_W-1:0]  host_pkt,
  input  logic              load_wr,
  input  logic              load_new,
  input  logic              dma_rd,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [PKT_W-1:0]  dma_pkt,
  input  logic              pkt_end,
  input  logic              urun_clr,
  output logic              dma_stall,
  output logic              underrun,
  output logic              auto_start
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic use_pkt, ahead, same_pkt, catch_up;
  logic stall_q, urun_q, fired_q, pulse_q, go;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (HAS_MODE_SEL) begin : g_mode
      assign use_pkt = mode_pkt;
    end else begin : g_nomode
      assign use_pkt = mode_pkt & 1'b0;
    end
  endgenerate

  assign ahead    = dma_addr > host_addr;
  assign same_pkt = dma_pkt == host_pkt;
  assign catch_up = early_en & dma_rd & ahead & (~use_pkt | same_pkt);

  assign dma_stall  = early_en & (stall_q | catch_up);
  assign underrun   = urun_q;
  assign auto_start = pulse_q;

  assign go = early_en & auto_en & ~rcv_sel & ~fired_q & (cnt_q >= auto_thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      if (pkt_end)       stall_q <= 1'b0;
      else if (catch_up) stall_q <= 1'b1;
      if (catch_up)      urun_q  <= 1'b1;
      else if (urun_clr) urun_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || load_new) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (load_wr && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (go) fired_q <= 1'b1;
      pulse_q <= go;
    end
  end

  a_r1_off_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !early_en |-> !dma_stall);
  a_r6_rise_follows_stall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(dma_stall));
  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !urun_clr |=> underrun);
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stall && !pkt_end && !load_new |=> (dma_stall || !early_en));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    auto_start |=> !auto_start);
  a_r9_gated_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auto_start) |-> $past(early_en && auto_en && !rcv_sel));
endmodule

// File: tb/etx_underrun_guard_tb_top.sv
module etx_underrun_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11, PW = 6, CW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic early_en = 0, mode_pkt = 0, auto_en = 0, rcv_sel = 0;
  logic [CW-1:0] auto_thresh = '0;
  logic [AW-1:0] host_addr = '0, dma_addr = '0;
  logic [PW-1:0] host_pkt = '0, dma_pkt = '0;
  logic load_wr = 0, load_new = 0, dma_rd = 0, pkt_end = 0, urun_clr = 0;
  logic dma_stall, underrun, auto_start, leg_stall, leg_urun, leg_auto;

  int checks = 0, fails = 0;
  logic [2:0] exp_q[$];
  string tag_q[$];
  logic m_stall = 0, m_urun = 0, m_fired = 0, m_pulse = 0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  etx_underrun_guard #(.ADDR_W(AW), .PKT_W(PW), .CNT_W(CW), .HAS_MODE_SEL(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .early_en(early_en), .mode_pkt(mode_pkt), .auto_en(auto_en),
    .rcv_sel(rcv_sel), .auto_thresh(auto_thresh), .host_addr(host_addr), .host_pkt(host_pkt),
    .load_wr(load_wr), .load_new(load_new), .dma_rd(dma_rd), .dma_addr(dma_addr),
    .dma_pkt(dma_pkt), .pkt_end(pkt_end), .urun_clr(urun_clr), .dma_stall(dma_stall),
    .underrun(underrun), .auto_start(auto_start));

  etx_underrun_guard #(.ADDR_W(AW), .PKT_W(PW), .CNT_W(CW), .HAS_MODE_SEL(1'b0)) leg_i (
    .clk(clk), .rst_n(rst_n), .early_en(early_en), .mode_pkt(mode_pkt), .auto_en(auto_en),
    .rcv_sel(rcv_sel), .auto_thresh(auto_thresh), .host_addr(host_addr), .host_pkt(host_pkt),
    .load_wr(load_wr), .load_new(load_new), .dma_rd(dma_rd), .dma_addr(dma_addr),
    .dma_pkt(dma_pkt), .pkt_end(pkt_end), .urun_clr(urun_clr), .dma_stall(leg_stall),
    .underrun(leg_urun), .auto_start(leg_auto));

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {stall,underrun,auto_start} actual %b expected %b", tag, act, exp);
    end
  endtask

  // Driver: expected outputs for the current cycle come from the model, then the model steps.
  task automatic cyc(input string tag);
    logic hit, go;
    hit = early_en && dma_rd && (dma_addr > host_addr) && (!mode_pkt || dma_pkt == host_pkt);
    exp_q.push_back({early_en && (m_stall || hit), m_urun, m_pulse});
    tag_q.push_back(tag);
    go = early_en && auto_en && !rcv_sel && !m_fired && (m_cnt >= int'(auto_thresh));
    if (hit) m_urun = 1; else if (urun_clr) m_urun = 0;
    if (pkt_end) m_stall = 0; else if (hit) m_stall = 1;
    if (load_new) begin m_cnt = 0; m_fired = 0; m_pulse = 0; end
    else begin
      if (load_wr && m_cnt < (1 << CW) - 1) m_cnt++;
      if (go) m_fired = 1;
      m_pulse = go;
    end
    @(negedge clk);
  endtask

  // Monitor: pops one expected item per cycle, a quarter period after the falling edge.
  initial forever begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) check(tag_q.pop_front(), {dma_stall, underrun, auto_start}, exp_q.pop_front());
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic idle(); dma_rd = 0; load_wr = 0; load_new = 0; pkt_end = 0; urun_clr = 0; endtask

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check("R10 in reset", {dma_stall, underrun, auto_start}, 3'b000);
    @(negedge clk); rst_n = 1;
    cyc("R10 after reset");

    early_en = 0; dma_rd = 1; dma_addr = 20; host_addr = 5;
    cyc("R1 disabled"); cyc("R1 disabled no flag");
    early_en = 1; dma_addr = 5;
    cyc("R2 equal no stall");
    dma_addr = 6;
    cyc("R2 ahead stalls");
    dma_addr = 3;
    cyc("R5 stall held R6 flag set"); cyc("R5 stall held");
    pkt_end = 1; dma_rd = 0;
    cyc("R5 end cycle");
    idle();
    cyc("R5 released"); 
    urun_clr = 1; cyc("R6 clear cycle"); idle();
    cyc("R6 cleared");

    mode_pkt = 1; dma_rd = 1; dma_addr = 30; host_addr = 10; dma_pkt = 3; host_pkt = 4;
    cyc("R3 pkt mismatch");
    #(CLK_PERIOD/4);
    checks++;
    if (leg_stall !== 1'b1) begin fails++; $display("FAIL R4: leg stall actual %b expected 1", leg_stall); end
    @(negedge clk);
    dma_pkt = 4;
    cyc("R3 pkt match stalls");
    dma_rd = 1; urun_clr = 1;
    cyc("R6 set beats clear");
    idle(); pkt_end = 1; cyc("R6 flag kept"); idle();
    urun_clr = 1; cyc("R6 clear"); idle(); mode_pkt = 0;
    cyc("R6 cleared again");

    auto_thresh = 4; auto_en = 1; load_new = 1; cyc("R8 new packet"); idle();
    for (int i = 0; i < 4; i++) begin load_wr = 1; cyc("R7 loading"); end
    idle();
    for (int i = 0; i < 4; i++) cyc("R7 R8 pulse once");
    load_wr = 1; cyc("R8 no second pulse"); idle();
    load_new = 1; cyc("R8 rearm"); idle();
    rcv_sel = 1;
    for (int i = 0; i < 5; i++) begin load_wr = 1; cyc("R9 rcv blocks"); end
    idle(); cyc("R9 rcv blocks idle");
    rcv_sel = 0; auto_en = 0; cyc("R9 auto off");
    early_en = 0; auto_en = 1; cyc("R9 early off"); cyc("R9 early off idle");
    early_en = 1; cyc("R7 fires when gates open"); cyc("R7 pulse"); cyc("R8 single");
    cyc("drain");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule